// File: doc/BRIEF.md
# Vector Length Configuration Unit

This unit works out how long a vector may be from the resources each microthread claims. A configure strobe supplies three things: the number of integer registers each thread uses, the number of floating-point registers each thread uses, and an enable mask over the register banks. From these the unit derives a maximum vector length. Every bank holds 256 register entries. The entries of one bank are divided among the threads according to their combined usage, the share is scaled by the number of enabled banks, and the result is capped at the microthread limit. The divide uses a small restoring divider that takes several cycles. While it runs, a busy flag is high and further configure strobes are refused.

A separate set-length request carries the length an application asks for. The unit grants the smaller of that value and the current maximum. The granted length stays in place until the next set-length request. A later reconfiguration does not change it.

Top module: `vlen_cfg_unit`

## Requirements
- R1: After reset, `vlMax` is 32, `vl` is 0 and `busy` is 0. The internal state starts as a bank mask of all ones and a usage of 32 integer and 32 floating-point registers.
- R2: A configure is accepted at a rising edge where `cfgValid` is 1 and `busy` is 0. At that edge the unit captures `cfgIntUse`, `cfgFpUse` and `cfgBankMask`, and `busy` is 1 from the next cycle.
- R3: When `cfgIntUse + cfgFpUse` is 2 or more, the new `vlMax` is floor(256 / (cfgIntUse + cfgFpUse - 1)) times the number of set bits in the mask, capped at 32. `busy` stays high for exactly 10 cycles, and `vlMax` takes its new value at the edge where `busy` falls.
- R4: When `cfgIntUse + cfgFpUse` is below 2, the new `vlMax` is 256 times the number of set bits in the mask, capped at 32. `busy` stays high for exactly 1 cycle.
- R5: A `cfgValid` that arrives while `busy` is 1 is ignored. The result that completes is the one for the configure already accepted, whatever values are presented during the busy window.
- R6: When `setVlValid` is 1 at an edge, `vl` becomes min(`vlMax`, `setVlReq`) at that edge. The `vlMax` used is the one present at the edge, so a request made while `busy` is 1 uses the previous maximum.
- R7: `vl` changes only at a set-length request. A configure, including one that lowers `vlMax`, leaves `vl` unchanged.
- R8: `vlMax` changes only at the edge where `busy` falls. The bank count is the population count of the 8-bit mask captured at the configure, so a mask of 0 gives a `vlMax` of 0.
- R9: `vlMax` never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgValid | input | 1 | Configure strobe |
| cfgIntUse | input | 6 | Integer registers used per microthread |
| cfgFpUse | input | 6 | Floating-point registers used per microthread |
| cfgBankMask | input | 8 | Enable mask, one bit per register bank |
| setVlValid | input | 1 | Set-length request strobe |
| setVlReq | input | 8 | Requested vector length |
| busy | output | 1 | High while a configure is being computed |
| vlMax | output | 6 | Current maximum vector length |
| vl | output | 6 | Current granted vector length |

## Verification
The bench tries every pair of integer and floating-point usage from 0 to 63, with a bank mask that varies from pair to pair. This sweep separates the below-two case from the divide case, finds truncation errors in the quotient, and shows whether the cap is applied before or after the bank scaling. A full sweep of all 256 masks is then run at two usages whose results stay below the cap. Here any error in the bank count shows up directly in `vlMax`, including the zero-bank mask. Set-length requests from 0 to 255 are checked against several maximum values, which exercises both sides of the clamp. Two directed sequences check three more points: a configure presented during `busy` has no effect, a request made during `busy` uses the old maximum, and a lowered maximum does not change `vl`.

// File: rtl/vlcfg_pkg.sv
package vlcfg_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture configure operands, seed divider
    logic step;    // one restoring divide step
    logic commit;  // write the clamped result to vlMax
  } vlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DIV  = 2'd1,
    ST_FIN  = 2'd2
  } vlState_t;

endpackage

// File: rtl/vlcfg_popcount.sv
module vlcfg_popcount #(
  parameter int WIDTH = 8,
  localparam int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] bits,
  output logic [CNT_W-1:0] count
);

  logic [CNT_W-1:0] partial [WIDTH+1];

  assign partial[0] = '0;

  for (genvar g = 0; g < WIDTH; g++) begin : g_acc
    assign partial[g+1] = partial[g] + CNT_W'(bits[g]);
  end

  assign count = partial[WIDTH];

endmodule

// File: rtl/vlcfg_ctrl.sv
module vlcfg_ctrl
  import vlcfg_pkg::*;
#(
  parameter int QUOT_W = 9,
  localparam int CNT_W = (QUOT_W > 1) ? $clog2(QUOT_W) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgValid,
  input  logic       cfgSmall,
  output vlStrobes_t strobes,
  output logic       busy
);

  vlState_t         state, stateNext;
  logic [CNT_W-1:0] stepCnt, stepCntNext;

  always_comb begin
    stateNext   = state;
    stepCntNext = stepCnt;
    strobes     = '0;
    unique case (state)
      ST_IDLE: begin
        if (cfgValid) begin
          strobes.load = 1'b1;
          stepCntNext  = '0;
          stateNext    = cfgSmall ? ST_FIN : ST_DIV;
        end
      end
      ST_DIV: begin
        strobes.step = 1'b1;
        stepCntNext  = stepCnt + CNT_W'(1);
        if (stepCnt == CNT_W'(QUOT_W - 1)) begin
          stateNext = ST_FIN;
        end
      end
      ST_FIN: begin
        strobes.commit = 1'b1;
        stateNext      = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
    end else begin
      state   <= stateNext;
      stepCnt <= stepCntNext;
    end
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/vlcfg_datapath.sv
module vlcfg_datapath
  import vlcfg_pkg::*;
#(
  parameter int ENTRIES   = 256,
  parameter int NUM_BANKS = 8,
  parameter int MAX_UTS   = 32,
  parameter int USE_W     = 6,
  parameter int REQ_W     = 8,
  parameter int RESET_USE = 32,
  localparam int QUOT_W   = $clog2(ENTRIES + 1),
  localparam int SUM_W    = USE_W + 1,
  localparam int LEN_W    = $clog2(MAX_UTS + 1),
  localparam int PC_W     = $clog2(NUM_BANKS + 1),
  localparam int PROD_W   = QUOT_W + PC_W,
  localparam int CMP_W    = REQ_W + LEN_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  vlStrobes_t           strobes,
  input  logic [USE_W-1:0]     cfgIntUse,
  input  logic [USE_W-1:0]     cfgFpUse,
  input  logic [NUM_BANKS-1:0] cfgBankMask,
  input  logic                 setVlValid,
  input  logic [REQ_W-1:0]     setVlReq,
  output logic                 cfgSmall,
  output logic [LEN_W-1:0]     vlMax,
  output logic [LEN_W-1:0]     vl
);

  // Reset result, derived from the reset usage and a full mask
  localparam int RST_SUM   = 2 * RESET_USE;
  localparam int RST_QUOT  = (RST_SUM < 2) ? ENTRIES : ENTRIES / (RST_SUM - 1);
  localparam int RST_PROD  = RST_QUOT * NUM_BANKS;
  localparam int RST_VLMAX = (RST_PROD > MAX_UTS) ? MAX_UTS : RST_PROD;

  logic [NUM_BANKS-1:0] bankMaskQ;
  logic [SUM_W-1:0]     divisorQ;
  logic [SUM_W-1:0]     remQ;
  logic [QUOT_W-1:0]    quotQ;
  logic [LEN_W-1:0]     vlMaxQ;
  logic [LEN_W-1:0]     vlQ;

  logic [SUM_W-1:0]     cfgSum;
  logic [SUM_W:0]       remShift;
  logic [SUM_W:0]       remDiff;
  logic                 fits;
  logic [SUM_W-1:0]     remNext;
  logic [QUOT_W-1:0]    quotNext;
  logic [PC_W-1:0]      bankCnt;
  logic [PROD_W-1:0]    product;
  logic [LEN_W-1:0]     clamped;
  logic [CMP_W-1:0]     reqExt;
  logic [CMP_W-1:0]     maxExt;
  logic [LEN_W-1:0]     grant;

  // Configure operand decode
  always_comb begin
    cfgSum   = SUM_W'(cfgIntUse) + SUM_W'(cfgFpUse);
    cfgSmall = (cfgSum < SUM_W'(2));
  end

  // One restoring step: dividend bits shift out of quotQ's top
  always_comb begin
    remShift = {remQ, quotQ[QUOT_W-1]};
    remDiff  = remShift - {1'b0, divisorQ};
    fits     = (remShift >= {1'b0, divisorQ});
    remNext  = fits ? remDiff[SUM_W-1:0] : remShift[SUM_W-1:0];
    quotNext = {quotQ[QUOT_W-2:0], fits};
  end

  vlcfg_popcount #(.WIDTH(NUM_BANKS)) u_popcount (
    .bits  (bankMaskQ),
    .count (bankCnt)
  );

  // Bank scaling and clamp to the microthread limit
  always_comb begin
    product = PROD_W'(quotQ) * PROD_W'(bankCnt);
    if (product > PROD_W'(MAX_UTS)) begin
      clamped = LEN_W'(MAX_UTS);
    end else begin
      clamped = product[LEN_W-1:0];
    end
  end

  // Set-length grant
  always_comb begin
    reqExt = CMP_W'(setVlReq);
    maxExt = CMP_W'(vlMaxQ);
    grant  = (reqExt > maxExt) ? vlMaxQ : reqExt[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankMaskQ <= '1;
      divisorQ  <= SUM_W'(RST_SUM - 1);
      remQ      <= '0;
      quotQ     <= QUOT_W'(RST_QUOT);
    end else if (strobes.load) begin
      bankMaskQ <= cfgBankMask;
      divisorQ  <= cfgSmall ? SUM_W'(1) : (cfgSum - SUM_W'(1));
      remQ      <= '0;
      quotQ     <= QUOT_W'(ENTRIES);
    end else if (strobes.step) begin
      remQ      <= remNext;
      quotQ     <= quotNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlMaxQ <= LEN_W'(RST_VLMAX);
    end else if (strobes.commit) begin
      vlMaxQ <= clamped;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vlQ <= '0;
    end else if (setVlValid) begin
      vlQ <= grant;
    end
  end

  assign vlMax = vlMaxQ;
  assign vl    = vlQ;

endmodule

// File: rtl/vlen_cfg_unit.sv
module vlen_cfg_unit
  import vlcfg_pkg::*;
#(
  parameter int ENTRIES   = 256,
  parameter int NUM_BANKS = 8,
  parameter int MAX_UTS   = 32,
  parameter int USE_W     = 6,
  parameter int REQ_W     = 8,
  parameter int RESET_USE = 32,
  localparam int QUOT_W   = $clog2(ENTRIES + 1),
  localparam int LEN_W    = $clog2(MAX_UTS + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgValid,
  input  logic [USE_W-1:0]     cfgIntUse,
  input  logic [USE_W-1:0]     cfgFpUse,
  input  logic [NUM_BANKS-1:0] cfgBankMask,
  input  logic                 setVlValid,
  input  logic [REQ_W-1:0]     setVlReq,
  output logic                 busy,
  output logic [LEN_W-1:0]     vlMax,
  output logic [LEN_W-1:0]     vl
);

  vlStrobes_t strobes;
  logic       cfgSmall;

  vlcfg_ctrl #(.QUOT_W(QUOT_W)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgValid (cfgValid),
    .cfgSmall (cfgSmall),
    .strobes  (strobes),
    .busy     (busy)
  );

  vlcfg_datapath #(
    .ENTRIES   (ENTRIES),
    .NUM_BANKS (NUM_BANKS),
    .MAX_UTS   (MAX_UTS),
    .USE_W     (USE_W),
    .REQ_W     (REQ_W),
    .RESET_USE (RESET_USE)
  ) u_datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .cfgIntUse   (cfgIntUse),
    .cfgFpUse    (cfgFpUse),
    .cfgBankMask (cfgBankMask),
    .setVlValid  (setVlValid),
    .setVlReq    (setVlReq),
    .cfgSmall    (cfgSmall),
    .vlMax       (vlMax),
    .vl          (vl)
  );

endmodule

// File: rtl/vlcfg_checker.sv
module vlcfg_checker #(
  parameter int MAX_UTS = 32,
  parameter int USE_W   = 6,
  parameter int REQ_W   = 8,
  parameter int LEN_W   = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             cfgValid,
  input logic [USE_W-1:0] cfgIntUse,
  input logic [USE_W-1:0] cfgFpUse,
  input logic             setVlValid,
  input logic [REQ_W-1:0] setVlReq,
  input logic             busy,
  input logic [LEN_W-1:0] vlMax,
  input logic [LEN_W-1:0] vl
);

  localparam int CMP_W = REQ_W + LEN_W;

  logic [USE_W:0]   useSum;
  logic             lowUse;
  logic [CMP_W-1:0] reqWide;
  logic [CMP_W-1:0] maxWide;
  logic [CMP_W-1:0] vlWide;

  assign useSum  = {1'b0, cfgIntUse} + {1'b0, cfgFpUse};
  assign lowUse  = (useSum < 2);
  assign reqWide = CMP_W'(setVlReq);
  assign maxWide = CMP_W'(vlMax);
  assign vlWide  = CMP_W'(vl);

  // R9
  vlmax_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    vlMax <= LEN_W'(MAX_UTS));

  // R2
  cfg_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !busy) |=> busy);

  // R4
  fast_path_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cfgValid && !busy && lowUse) |=> busy ##1 !busy);

  // R6
  vl_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    setVlValid |=> (vlWide <= $past(maxWide)));

  // R6
  vl_exact_chk: assert property (@(posedge clk) disable iff (!rstN)
    (setVlValid && (reqWide <= maxWide)) |=> (vlWide == $past(reqWide)));

  // R7
  vl_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !setVlValid |=> $stable(vl));

  // R8
  vlmax_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(vlMax) |-> $fell(busy));

endmodule

bind vlen_cfg_unit vlcfg_checker #(
  .MAX_UTS (MAX_UTS),
  .USE_W   (USE_W),
  .REQ_W   (REQ_W),
  .LEN_W   (LEN_W)
) u_vlcfg_checker (
  .clk        (clk),
  .rstN       (rstN),
  .cfgValid   (cfgValid),
  .cfgIntUse  (cfgIntUse),
  .cfgFpUse   (cfgFpUse),
  .setVlValid (setVlValid),
  .setVlReq   (setVlReq),
  .busy       (busy),
  .vlMax      (vlMax),
  .vl         (vl)
);

// File: tb/vlen_cfg_unit_bench.sv
module vlen_cfg_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_BUSY   = 10;
  localparam int FAST_BUSY  = 1;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgValid = 1'b0;
  logic [5:0] cfgIntUse = '0;
  logic [5:0] cfgFpUse = '0;
  logic [7:0] cfgBankMask = '0;
  logic       setVlValid = 1'b0;
  logic [7:0] setVlReq = '0;
  logic       busy;
  logic [5:0] vlMax;
  logic [5:0] vl;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_cfg_unit u_vlen_cfg_unit (
    .clk         (clk),
    .rstN        (rstN),
    .cfgValid    (cfgValid),
    .cfgIntUse   (cfgIntUse),
    .cfgFpUse    (cfgFpUse),
    .cfgBankMask (cfgBankMask),
    .setVlValid  (setVlValid),
    .setVlReq    (setVlReq),
    .busy        (busy),
    .vlMax       (vlMax),
    .vl          (vl)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expMax(input int iu, input int fu, input int mask);
    int s, pc, q, p;
    s  = iu + fu;
    pc = $countones(mask[7:0]);
    q  = (s < 2) ? 256 : 256 / (s - 1);
    p  = q * pc;
    return (p > 32) ? 32 : p;
  endfunction

  // Configure and wait until busy drops; returns busy-high cycle count
  task automatic configure(input int iu, input int fu, input int mask, output int cycles);
    @(negedge clk);
    cfgValid    = 1'b1;
    cfgIntUse   = 6'(iu);
    cfgFpUse    = 6'(fu);
    cfgBankMask = 8'(mask);
    @(negedge clk);
    cfgValid = 1'b0;
    cycles = 0;
    while (busy) begin
      cycles++;
      @(negedge clk);
    end
  endtask

  task automatic cfgAndCheck(input int iu, input int fu, input int mask, input string tag);
    int cyc, e;
    configure(iu, fu, mask, cyc);
    e = expMax(iu, fu, mask);
    check(vlMax == 6'(e), tag, int'(vlMax), e);
    if (iu + fu < 2)
      check(cyc == FAST_BUSY, "R4 busy length", cyc, FAST_BUSY);
    else
      check(cyc == DIV_BUSY, "R3 busy length", cyc, DIV_BUSY);
  endtask

  task automatic setLen(input int req);
    @(negedge clk);
    setVlValid = 1'b1;
    setVlReq   = 8'(req);
    @(negedge clk);
    setVlValid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int cyc, e, vlBefore;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(vlMax == 6'd32, "R1 vlMax reset", int'(vlMax), 32);
    check(vl == 6'd0, "R1 vl reset", int'(vl), 0);
    check(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(vlMax == 6'd32 && vl == 6'd0 && !busy, "R1 after release", int'(vlMax), 32);

    // R3 R4 sweep of every usage pair
    for (int iu = 0; iu < 64; iu++) begin
      for (int fu = 0; fu < 64; fu++) begin
        int m;
        m = (iu * 37 + fu * 11 + 1) & 8'hFF;
        cfgAndCheck(iu, fu, m, (iu + fu < 2) ? "R4 vlMax small usage" : "R3 vlMax divide");
      end
    end

    // R8 all masks at unclamped usages
    for (int m = 0; m < 256; m++) begin
      cfgAndCheck(63, 63, m, "R8 mask sweep q=2");
      cfgAndCheck(40, 33, m, "R8 mask sweep q=3");
    end

    // R5 configure during busy is ignored
    @(negedge clk);
    cfgValid = 1'b1; cfgIntUse = 6'd63; cfgFpUse = 6'd63; cfgBankMask = 8'hFF;
    @(negedge clk);
    cfgIntUse = 6'd0; cfgFpUse = 6'd0; cfgBankMask = 8'h0F;
    repeat (5) @(negedge clk);
    cfgValid = 1'b0;
    while (busy) @(negedge clk);
    check(vlMax == 6'd16, "R5 busy configure ignored", int'(vlMax), 16);
    repeat (2) @(negedge clk);
    check(vlMax == 6'd16 && !busy, "R5 no late accept", int'(vlMax), 16);

    // R6 R7 request during busy uses old maximum; lowered max keeps vl
    cfgAndCheck(0, 0, 8'hFF, "R4 back to 32");
    @(negedge clk);
    cfgValid = 1'b1; cfgIntUse = 6'd63; cfgFpUse = 6'd63; cfgBankMask = 8'hFF;
    @(negedge clk);
    cfgValid = 1'b0;
    setVlValid = 1'b1; setVlReq = 8'd255;
    @(negedge clk);
    setVlValid = 1'b0;
    check(vl == 6'd32, "R6 request during busy", int'(vl), 32);
    while (busy) @(negedge clk);
    check(vlMax == 6'd16, "R3 vlMax after lower", int'(vlMax), 16);
    check(vl == 6'd32, "R7 vl kept after configure", int'(vl), 32);
    setLen(255);
    check(vl == 6'd16, "R6 clamp to new max", int'(vl), 16);

    // R6 request sweep against several maxima
    for (int k = 0; k < 5; k++) begin
      int iu, fu, m;
      case (k)
        0: begin iu = 63; fu = 63; m = 8'h00; end
        1: begin iu = 63; fu = 63; m = 8'h01; end
        2: begin iu = 63; fu = 63; m = 8'hFF; end
        3: begin iu = 40; fu = 33; m = 8'hFF; end
        default: begin iu = 1; fu = 0; m = 8'h01; end
      endcase
      cfgAndCheck(iu, fu, m, "R3 sweep setup");
      e = expMax(iu, fu, m);
      for (int r = 0; r < 256; r++) begin
        int ev;
        setLen(r);
        ev = (r < e) ? r : e;
        check(vl == 6'(ev), "R6 set-length clamp", int'(vl), ev);
      end
      vlBefore = int'(vl);
      repeat (3) @(negedge clk);
      check(int'(vl) == vlBefore, "R7 vl holds without request", int'(vl), vlBefore);
    end

    // R9 cap observed at the largest result
    configure(1, 1, 8'hFF, cyc);
    check(vlMax == 6'd32, "R9 cap at 32", int'(vlMax), 32);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule